// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register bank behind a processor's system-control coprocessor. The core reaches it through one move-to/move-from access port. Each access carries a primary register number, a secondary register number, a first-level opcode and a second-level opcode. Together these four fields pick a storage register, a read-only identification value or a maintenance operation. The bank holds the control word, the translation table base, the domain access word, the data and instruction fault status words, the fault address, the two cache lockdown words, the TLB lockdown word, the 7-bit process ID and the context ID. Their live values drive output ports, so the caches and the MMU can use them.

Writes to the cache maintenance space (primary 7) and the TLB maintenance space (primary 8) store nothing. Each one becomes a one-cycle strobe that carries an operation code and the written word as its argument. The caches and the MMU act on these strobes. Abort inputs load the fault registers directly, with no software involved. A write to the context ID raises a one-cycle pulse next to the context ID output.

Top module: `sysctl_regbank`

## Requirements
- R1: Read timing. A read request (acc_valid=1, acc_write=0) raises rvalid for exactly one cycle, in the cycle after the request, and rdata carries the result in that same cycle. In every cycle without a read result, rdata is zero.
- R2: Identification values. With primary 0, secondary 0 and first opcode 0, second opcode 0 returns ID_VALUE, 1 returns CTYPE_VALUE and 2 returns TCM_VALUE. Writes to these selectors change nothing.
- R3: Plain storage registers. Each is addressed as (primary, secondary, second opcode) with first opcode 0: control (1,0,0), domain (3,0,0), data cache lockdown (9,0,0), instruction cache lockdown (9,0,1) and TLB lockdown (10,0,0). Each stores all 32 written bits, reads them back and drives them on its output port. Control resets to CTRL_RESET and the others reset to zero.
- R4: Translation table base (2,0,0). Only bits [31:14] are stored. Bits [13:0] of a write are ignored, and those bits are zero on both readback and the ttb_base output.
- R5: Fault status words. The data fault status (5,0,0) and the instruction fault status (5,0,1) are separate 32-bit registers, and software can read and write each of them.
- R6: Abort capture. A data abort loads abort_status into the data fault status and abort_addr into the fault address. A prefetch abort loads abort_status into the instruction fault status only, and leaves the fault address and the data fault status unchanged. In a cycle that has both an abort and a software write to the same register, the abort value is stored.
- R7: Fault address (6,0,0). Software can read and write it.
- R8: Maintenance strobes. A write to a defined maintenance selector raises maint_valid for exactly one cycle, in the cycle after the write. In that cycle maint_op carries the code and maint_arg carries the written word. Codes are given as (primary,secondary,second opcode)=code. Cache space: (7,7,0)=1, (7,5,0)=2, (7,5,1)=3, (7,5,2)=4, (7,13,1)=5, (7,6,0)=6, (7,6,1)=7, (7,6,2)=8, (7,10,1)=9, (7,10,2)=10, (7,14,1)=11, (7,14,2)=12, (7,10,4)=13, (7,0,4)=14. TLB space: (8,7,0)=15, (8,7,1)=16, (8,5,0)=17, (8,5,1)=18, (8,6,0)=19, (8,6,1)=20. When maint_valid is low, maint_op and maint_arg are zero.
- R9: Undefined selectors. A write to an undefined selector raises no strobe and changes no register. A read of an undefined selector, a maintenance selector or another write-only selector returns zero, and rvalid still rises. Reads never raise a strobe.
- R10: Any access with a nonzero first opcode is undefined and is handled as in R9.
- R11: Process ID (13,0,0). It is 7 bits wide, held in bits [6:0]. Reads return zero in bits [31:7], and the register resets to zero.
- R12: Context ID (13,0,1). It stores 32 bits and drives ctx_id continuously. Each write raises ctx_wr_pulse for one cycle, in the cycle after the write, and the new value is already on ctx_id in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request for this cycle |
| acc_write | input | 1 | 1 for move-to (write), 0 for move-from (read) |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_opc1 | input | 3 | First-level opcode |
| acc_opc2 | input | 3 | Second-level opcode |
| acc_wdata | input | 32 | Write data |
| rdata | output | 32 | Read result, valid with rvalid |
| rvalid | output | 1 | Read result strobe |
| data_abort | input | 1 | Data abort capture request |
| prefetch_abort | input | 1 | Prefetch abort capture request |
| abort_status | input | 32 | Fault status to capture |
| abort_addr | input | 32 | Faulting address (data aborts only) |
| ctrl_word | output | 32 | Control register value |
| ttb_base | output | 32 | Table base, bits [13:0] zero |
| domain_word | output | 32 | Domain access word |
| dcache_lock | output | 32 | Data cache lockdown word |
| icache_lock | output | 32 | Instruction cache lockdown word |
| tlb_lock | output | 32 | TLB lockdown word |
| proc_id | output | 7 | Process ID |
| ctx_id | output | 32 | Context ID |
| ctx_wr_pulse | output | 1 | One-cycle pulse after each context ID write |
| maint_valid | output | 1 | Maintenance strobe |
| maint_op | output | 5 | Maintenance operation code |
| maint_arg | output | 32 | Maintenance argument word |

## Verification
The hardest case to reach from the ports is a hardware abort and a software write landing on the same fault register in the same cycle. Close behind it is a prefetch abort that must leave the fault address untouched. The stimulus raises an abort input on the same falling edge that presents a software write to the data fault status, then reads the register back through the normal access port. Separately, it preloads a known fault address by software, fires a prefetch abort carrying a different address, and reads both the fault address and the two status words.

// File: rtl/sysctl_pkg.sv
// Shared definitions for the system control register bank.
// Declares the access field widths, the register selector type and the
// maintenance operation codes. The operation code values are visible on
// the maint_op port, so their numeric order matters.
package sysctl_pkg;

    localparam int CRN_W  = 4;
    localparam int CRM_W  = 4;
    localparam int OPC1_W = 3;
    localparam int OPC2_W = 3;
    localparam int WORD_W = 32;
    localparam int OP_W   = 5;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_ID, SEL_CTYPE, SEL_TCM, SEL_CTRL, SEL_TTB, SEL_DOMAIN,
        SEL_DFSR, SEL_IFSR, SEL_FAR, SEL_DLOCK, SEL_ILOCK, SEL_TLBLOCK,
        SEL_PID, SEL_CTXID
    } reg_sel_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE            = 5'd0,
        OP_INV_ALL_CACHE   = 5'd1,
        OP_INV_ICACHE      = 5'd2,
        OP_INV_ILINE_VA    = 5'd3,
        OP_INV_ILINE_IDX   = 5'd4,
        OP_PREFETCH_ILINE  = 5'd5,
        OP_INV_DCACHE      = 5'd6,
        OP_INV_DLINE_VA    = 5'd7,
        OP_INV_DLINE_IDX   = 5'd8,
        OP_CLEAN_DLINE_VA  = 5'd9,
        OP_CLEAN_DLINE_IDX = 5'd10,
        OP_FLUSH_DLINE_VA  = 5'd11,
        OP_FLUSH_DLINE_IDX = 5'd12,
        OP_DRAIN_WBUF      = 5'd13,
        OP_WAIT_IRQ        = 5'd14,
        OP_INV_TLB         = 5'd15,
        OP_INV_TLB_VA      = 5'd16,
        OP_INV_ITLB        = 5'd17,
        OP_INV_ITLB_VA     = 5'd18,
        OP_INV_DTLB        = 5'd19,
        OP_INV_DTLB_VA     = 5'd20
    } maint_op_e;

endpackage

// File: rtl/sysctl_decode.sv
// Access decoder: maps (primary, secondary, first opcode, second opcode)
// to a storage selector or a maintenance operation code.
// Assumes: purely combinational. A nonzero first opcode is always
// undefined. At most one of sel_o / op_o is non-idle.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [CRN_W-1:0]  crn_i,
    input  logic [CRM_W-1:0]  crm_i,
    input  logic [OPC1_W-1:0] opc1_i,
    input  logic [OPC2_W-1:0] opc2_i,
    output reg_sel_e          sel_o,
    output maint_op_e         op_o
);

    logic crm_zero;
    assign crm_zero = (crm_i == '0);

    // Purpose: resolve the four access fields into a selector or an operation.
    always_comb begin
        sel_o = SEL_NONE;
        op_o  = OP_NONE;
        if (opc1_i == '0) begin
            case (crn_i)
                4'd0: if (crm_zero) begin
                    case (opc2_i)
                        3'd0:    sel_o = SEL_ID;
                        3'd1:    sel_o = SEL_CTYPE;
                        3'd2:    sel_o = SEL_TCM;
                        default: sel_o = SEL_NONE;
                    endcase
                end
                4'd1:  if (crm_zero && opc2_i == 3'd0) sel_o = SEL_CTRL;
                4'd2:  if (crm_zero && opc2_i == 3'd0) sel_o = SEL_TTB;
                4'd3:  if (crm_zero && opc2_i == 3'd0) sel_o = SEL_DOMAIN;
                4'd5: if (crm_zero) begin
                    if (opc2_i == 3'd0)      sel_o = SEL_DFSR;
                    else if (opc2_i == 3'd1) sel_o = SEL_IFSR;
                end
                4'd6:  if (crm_zero && opc2_i == 3'd0) sel_o = SEL_FAR;
                4'd9: if (crm_zero) begin
                    if (opc2_i == 3'd0)      sel_o = SEL_DLOCK;
                    else if (opc2_i == 3'd1) sel_o = SEL_ILOCK;
                end
                4'd10: if (crm_zero && opc2_i == 3'd0) sel_o = SEL_TLBLOCK;
                4'd13: if (crm_zero) begin
                    if (opc2_i == 3'd0)      sel_o = SEL_PID;
                    else if (opc2_i == 3'd1) sel_o = SEL_CTXID;
                end
                4'd7: begin
                    case ({crm_i, opc2_i})
                        {4'd7,  3'd0}: op_o = OP_INV_ALL_CACHE;
                        {4'd5,  3'd0}: op_o = OP_INV_ICACHE;
                        {4'd5,  3'd1}: op_o = OP_INV_ILINE_VA;
                        {4'd5,  3'd2}: op_o = OP_INV_ILINE_IDX;
                        {4'd13, 3'd1}: op_o = OP_PREFETCH_ILINE;
                        {4'd6,  3'd0}: op_o = OP_INV_DCACHE;
                        {4'd6,  3'd1}: op_o = OP_INV_DLINE_VA;
                        {4'd6,  3'd2}: op_o = OP_INV_DLINE_IDX;
                        {4'd10, 3'd1}: op_o = OP_CLEAN_DLINE_VA;
                        {4'd10, 3'd2}: op_o = OP_CLEAN_DLINE_IDX;
                        {4'd14, 3'd1}: op_o = OP_FLUSH_DLINE_VA;
                        {4'd14, 3'd2}: op_o = OP_FLUSH_DLINE_IDX;
                        {4'd10, 3'd4}: op_o = OP_DRAIN_WBUF;
                        {4'd0,  3'd4}: op_o = OP_WAIT_IRQ;
                        default:       op_o = OP_NONE;
                    endcase
                end
                4'd8: begin
                    case ({crm_i, opc2_i})
                        {4'd7, 3'd0}: op_o = OP_INV_TLB;
                        {4'd7, 3'd1}: op_o = OP_INV_TLB_VA;
                        {4'd5, 3'd0}: op_o = OP_INV_ITLB;
                        {4'd5, 3'd1}: op_o = OP_INV_ITLB_VA;
                        {4'd6, 3'd0}: op_o = OP_INV_DTLB;
                        {4'd6, 3'd1}: op_o = OP_INV_DTLB_VA;
                        default:      op_o = OP_NONE;
                    endcase
                end
                default: begin
                    sel_o = SEL_NONE;
                    op_o  = OP_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sysctl_store.sv
// Storage, abort capture and registered read path for the register bank.
// Assumes: at most one access per cycle, and the selector comes from
// sysctl_decode in the same cycle. Abort capture takes priority over a
// software write to the same register. Read data leaves one cycle after
// the request and is zero otherwise.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE    = 32'h0,
    parameter logic [WORD_W-1:0] CTYPE_VALUE = 32'h0,
    parameter logic [WORD_W-1:0] TCM_VALUE   = 32'h0,
    parameter logic [WORD_W-1:0] CTRL_RESET  = 32'h0,
    parameter int                TTB_LSB     = 14,
    parameter int                PID_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  reg_sel_e          sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              data_abort,
    input  logic              prefetch_abort,
    input  logic [WORD_W-1:0] abort_status,
    input  logic [WORD_W-1:0] abort_addr,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] ttb_o,
    output logic [WORD_W-1:0] domain_o,
    output logic [WORD_W-1:0] dlock_o,
    output logic [WORD_W-1:0] ilock_o,
    output logic [WORD_W-1:0] tlblock_o,
    output logic [PID_W-1:0]  pid_o,
    output logic [WORD_W-1:0] ctx_o,
    output logic              ctx_pulse_o
);

    localparam int TTB_HI_W = WORD_W - TTB_LSB;

    logic                wr, rd;
    logic [WORD_W-1:0]   ctrl_q, domain_q, dlock_q, ilock_q, tlblock_q;
    logic [WORD_W-1:0]   dfsr_q, ifsr_q, far_q, ctx_q;
    logic [TTB_HI_W-1:0] ttb_q;
    logic [PID_W-1:0]    pid_q;
    logic                ctx_pulse_q;
    logic [WORD_W-1:0]   rd_mux;
    logic [WORD_W-1:0]   rdata_q;
    logic                rvalid_q;

    assign wr = acc_valid && acc_write;
    assign rd = acc_valid && !acc_write;

    // Purpose: plain software-written words, all bits kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= CTRL_RESET;
            domain_q  <= '0;
            dlock_q   <= '0;
            ilock_q   <= '0;
            tlblock_q <= '0;
        end else if (wr) begin
            if (sel_i == SEL_CTRL)    ctrl_q    <= wdata_i;
            if (sel_i == SEL_DOMAIN)  domain_q  <= wdata_i;
            if (sel_i == SEL_DLOCK)   dlock_q   <= wdata_i;
            if (sel_i == SEL_ILOCK)   ilock_q   <= wdata_i;
            if (sel_i == SEL_TLBLOCK) tlblock_q <= wdata_i;
        end
    end

    // Purpose: table base keeps only its aligned upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ttb_q <= '0;
        else if (wr && sel_i == SEL_TTB) ttb_q <= wdata_i[WORD_W-1:TTB_LSB];
    end

    // Purpose: data fault status and fault address, data abort wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dfsr_q <= '0;
            far_q  <= '0;
        end else begin
            if (data_abort)                    dfsr_q <= abort_status;
            else if (wr && sel_i == SEL_DFSR)  dfsr_q <= wdata_i;
            if (data_abort)                    far_q  <= abort_addr;
            else if (wr && sel_i == SEL_FAR)   far_q  <= wdata_i;
        end
    end

    // Purpose: instruction fault status, prefetch abort wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ifsr_q <= '0;
        else if (prefetch_abort)           ifsr_q <= abort_status;
        else if (wr && sel_i == SEL_IFSR)  ifsr_q <= wdata_i;
    end

    // Purpose: process ID, context ID and the context write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_q       <= '0;
            ctx_q       <= '0;
            ctx_pulse_q <= 1'b0;
        end else begin
            if (wr && sel_i == SEL_PID)   pid_q <= wdata_i[PID_W-1:0];
            if (wr && sel_i == SEL_CTXID) ctx_q <= wdata_i;
            ctx_pulse_q <= wr && (sel_i == SEL_CTXID);
        end
    end

    // Purpose: select the word a read of the current selector returns.
    always_comb begin
        case (sel_i)
            SEL_ID:      rd_mux = ID_VALUE;
            SEL_CTYPE:   rd_mux = CTYPE_VALUE;
            SEL_TCM:     rd_mux = TCM_VALUE;
            SEL_CTRL:    rd_mux = ctrl_q;
            SEL_TTB:     rd_mux = {ttb_q, {TTB_LSB{1'b0}}};
            SEL_DOMAIN:  rd_mux = domain_q;
            SEL_DFSR:    rd_mux = dfsr_q;
            SEL_IFSR:    rd_mux = ifsr_q;
            SEL_FAR:     rd_mux = far_q;
            SEL_DLOCK:   rd_mux = dlock_q;
            SEL_ILOCK:   rd_mux = ilock_q;
            SEL_TLBLOCK: rd_mux = tlblock_q;
            SEL_PID:     rd_mux = {{(WORD_W-PID_W){1'b0}}, pid_q};
            SEL_CTXID:   rd_mux = ctx_q;
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: register the read result, zero when no read is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            rdata_q  <= rd ? rd_mux : '0;
        end
    end

    assign rdata_o     = rdata_q;
    assign rvalid_o    = rvalid_q;
    assign ctrl_o      = ctrl_q;
    assign ttb_o       = {ttb_q, {TTB_LSB{1'b0}}};
    assign domain_o    = domain_q;
    assign dlock_o     = dlock_q;
    assign ilock_o     = ilock_q;
    assign tlblock_o   = tlblock_q;
    assign pid_o       = pid_q;
    assign ctx_o       = ctx_q;
    assign ctx_pulse_o = ctx_pulse_q;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid_q); // R1
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata_q == '0)); // R1
    AST_TTB_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel_i == SEL_TTB) |=> (rdata_q[TTB_LSB-1:0] == '0)); // R4
    AST_FAR_PREFETCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_abort && !data_abort && !(wr && sel_i == SEL_FAR)) |=> $stable(far_q)); // R6
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel_i == SEL_NONE) |=> (rdata_q == '0)); // R9
    AST_PID_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pid_q == '0)); // R11
    AST_CTX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_i == SEL_CTXID) |=> (ctx_pulse_q && ctx_q == $past(wdata_i))); // R12

endmodule

// File: rtl/sysctl_maint.sv
// Maintenance strobe stage: turns a decoded maintenance write into a
// registered one-cycle strobe with its code and argument.
// Assumes: op_i is OP_NONE for every non-maintenance selector. Outputs
// are zero whenever the strobe is low.
module sysctl_maint
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  maint_op_e         op_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              valid_o,
    output maint_op_e         op_o,
    output logic [WORD_W-1:0] arg_o
);

    logic fire;
    assign fire = acc_valid && acc_write && (op_i != OP_NONE);

    // Purpose: one-cycle strobe register for each maintenance write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            op_o    <= OP_NONE;
            arg_o   <= '0;
        end else begin
            valid_o <= fire;
            op_o    <= fire ? op_i : OP_NONE;
            arg_o   <= fire ? wdata_i : '0;
        end
    end

    AST_MAINT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (valid_o && op_o == $past(op_i) && arg_o == $past(wdata_i))); // R8
    AST_NO_STROBE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !valid_o); // R9

endmodule

// File: rtl/sysctl_regbank.sv
// Top of the system control coprocessor register bank.
// Connects the access decoder, the storage/read path and the maintenance
// strobe stage. Assumes one access per cycle, synchronous active-low reset.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h5A01_0C21,
    parameter logic [31:0] CTYPE_VALUE = 32'h1D15_2152,
    parameter logic [31:0] TCM_VALUE   = 32'h0000_0000,
    parameter logic [31:0] CTRL_RESET  = 32'h0005_0078,
    parameter int          TTB_LSB     = 14,
    parameter int          PID_W       = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_valid,
    input  logic         acc_write,
    input  logic [3:0]   acc_crn,
    input  logic [3:0]   acc_crm,
    input  logic [2:0]   acc_opc1,
    input  logic [2:0]   acc_opc2,
    input  logic [31:0]  acc_wdata,
    output logic [31:0]  rdata,
    output logic         rvalid,
    input  logic         data_abort,
    input  logic         prefetch_abort,
    input  logic [31:0]  abort_status,
    input  logic [31:0]  abort_addr,
    output logic [31:0]  ctrl_word,
    output logic [31:0]  ttb_base,
    output logic [31:0]  domain_word,
    output logic [31:0]  dcache_lock,
    output logic [31:0]  icache_lock,
    output logic [31:0]  tlb_lock,
    output logic [PID_W-1:0] proc_id,
    output logic [31:0]  ctx_id,
    output logic         ctx_wr_pulse,
    output logic         maint_valid,
    output logic [4:0]   maint_op,
    output logic [31:0]  maint_arg
);

    reg_sel_e  sel;
    maint_op_e dec_op;
    maint_op_e strobe_op;

    sysctl_decode u_decode (
        .crn_i  (acc_crn),
        .crm_i  (acc_crm),
        .opc1_i (acc_opc1),
        .opc2_i (acc_opc2),
        .sel_o  (sel),
        .op_o   (dec_op)
    );

    sysctl_store #(
        .ID_VALUE    (ID_VALUE),
        .CTYPE_VALUE (CTYPE_VALUE),
        .TCM_VALUE   (TCM_VALUE),
        .CTRL_RESET  (CTRL_RESET),
        .TTB_LSB     (TTB_LSB),
        .PID_W       (PID_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_valid      (acc_valid),
        .acc_write      (acc_write),
        .sel_i          (sel),
        .wdata_i        (acc_wdata),
        .data_abort     (data_abort),
        .prefetch_abort (prefetch_abort),
        .abort_status   (abort_status),
        .abort_addr     (abort_addr),
        .rdata_o        (rdata),
        .rvalid_o       (rvalid),
        .ctrl_o         (ctrl_word),
        .ttb_o          (ttb_base),
        .domain_o       (domain_word),
        .dlock_o        (dcache_lock),
        .ilock_o        (icache_lock),
        .tlblock_o      (tlb_lock),
        .pid_o          (proc_id),
        .ctx_o          (ctx_id),
        .ctx_pulse_o    (ctx_wr_pulse)
    );

    sysctl_maint u_maint (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .op_i      (dec_op),
        .wdata_i   (acc_wdata),
        .valid_o   (maint_valid),
        .op_o      (strobe_op),
        .arg_o     (maint_arg)
    );

    assign maint_op = strobe_op;

endmodule

// File: tb/sysctl_regbank_tb_top.sv
// Directed bench for sysctl_regbank: one task per scenario, each checking
// its own results at the falling edge after the capturing rising edge.
module sysctl_regbank_tb_top;

    localparam logic [31:0] P_ID    = 32'h5A01_0C21;
    localparam logic [31:0] P_CTYPE = 32'h1D15_2152;
    localparam logic [31:0] P_TCM   = 32'h0000_0003;
    localparam logic [31:0] P_CTRL  = 32'h0005_0078;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [2:0]  acc_opc1 = '0, acc_opc2 = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        data_abort = 1'b0, prefetch_abort = 1'b0;
    logic [31:0] abort_status = '0, abort_addr = '0;
    logic [31:0] ctrl_word, ttb_base, domain_word, dcache_lock, icache_lock, tlb_lock;
    logic [6:0]  proc_id;
    logic [31:0] ctx_id;
    logic        ctx_wr_pulse;
    logic        maint_valid;
    logic [4:0]  maint_op;
    logic [31:0] maint_arg;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sysctl_regbank #(
        .ID_VALUE(P_ID), .CTYPE_VALUE(P_CTYPE), .TCM_VALUE(P_TCM), .CTRL_RESET(P_CTRL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_opc1(acc_opc1), .acc_opc2(acc_opc2),
        .acc_wdata(acc_wdata), .rdata(rdata), .rvalid(rvalid),
        .data_abort(data_abort), .prefetch_abort(prefetch_abort),
        .abort_status(abort_status), .abort_addr(abort_addr),
        .ctrl_word(ctrl_word), .ttb_base(ttb_base), .domain_word(domain_word),
        .dcache_lock(dcache_lock), .icache_lock(icache_lock), .tlb_lock(tlb_lock),
        .proc_id(proc_id), .ctx_id(ctx_id), .ctx_wr_pulse(ctx_wr_pulse),
        .maint_valid(maint_valid), .maint_op(maint_op), .maint_arg(maint_arg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access; returns at the falling edge where registered results show.
    task automatic access(input logic wr, input logic [3:0] crn, input logic [3:0] crm,
                          input logic [2:0] opc1, input logic [2:0] opc2,
                          input logic [31:0] d);
        acc_valid = 1'b1; acc_write = wr;
        acc_crn = crn; acc_crm = crm; acc_opc1 = opc1; acc_opc2 = opc2; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
    endtask

    task automatic wr_reg(input logic [3:0] crn, input logic [3:0] crm,
                          input logic [2:0] opc2, input logic [31:0] d);
        access(1'b1, crn, crm, 3'd0, opc2, d);
    endtask

    task automatic rd_check(input string req, input logic [3:0] crn, input logic [3:0] crm,
                            input logic [2:0] opc1, input logic [2:0] opc2,
                            input logic [31:0] exp);
        access(1'b0, crn, crm, opc1, opc2, 32'h0);
        check({req, " rvalid"}, {31'd0, rvalid}, 32'd1);
        check(req, rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 reset rvalid", {31'd0, rvalid}, 32'd0);
        check("R3 reset ctrl", ctrl_word, P_CTRL);
        check("R11 reset pid", {25'd0, proc_id}, 32'd0);
        check("R12 reset ctx", ctx_id, 32'd0);
        check("R8 reset strobe", {31'd0, maint_valid}, 32'd0);
    endtask

    task automatic t_read_timing;
        rd_check("R1 read", 4'd1, 4'd0, 3'd0, 3'd0, P_CTRL);
        @(negedge clk);
        check("R1 rvalid drops", {31'd0, rvalid}, 32'd0);
        check("R1 idle rdata", rdata, 32'd0);
    endtask

    task automatic t_ident;
        rd_check("R2 id", 4'd0, 4'd0, 3'd0, 3'd0, P_ID);
        rd_check("R2 ctype", 4'd0, 4'd0, 3'd0, 3'd1, P_CTYPE);
        rd_check("R2 tcm", 4'd0, 4'd0, 3'd0, 3'd2, P_TCM);
        wr_reg(4'd0, 4'd0, 3'd0, 32'hDEAD_BEEF);
        rd_check("R2 id after write", 4'd0, 4'd0, 3'd0, 3'd0, P_ID);
    endtask

    task automatic t_plain;
        wr_reg(4'd1, 4'd0, 3'd0, 32'h1234_5678);
        wr_reg(4'd3, 4'd0, 3'd0, 32'h5555_AAAA);
        wr_reg(4'd9, 4'd0, 3'd0, 32'h0000_000E);
        wr_reg(4'd9, 4'd0, 3'd1, 32'h0000_000D);
        wr_reg(4'd10, 4'd0, 3'd0, 32'h1C00_0000);
        rd_check("R3 ctrl", 4'd1, 4'd0, 3'd0, 3'd0, 32'h1234_5678);
        rd_check("R3 domain", 4'd3, 4'd0, 3'd0, 3'd0, 32'h5555_AAAA);
        rd_check("R3 dlock", 4'd9, 4'd0, 3'd0, 3'd0, 32'h0000_000E);
        rd_check("R3 ilock", 4'd9, 4'd0, 3'd0, 3'd1, 32'h0000_000D);
        rd_check("R3 tlblock", 4'd10, 4'd0, 3'd0, 3'd0, 32'h1C00_0000);
        check("R3 ctrl port", ctrl_word, 32'h1234_5678);
        check("R3 domain port", domain_word, 32'h5555_AAAA);
        check("R3 dlock port", dcache_lock, 32'h0000_000E);
        check("R3 ilock port", icache_lock, 32'h0000_000D);
        check("R3 tlblock port", tlb_lock, 32'h1C00_0000);
    endtask

    task automatic t_ttb;
        wr_reg(4'd2, 4'd0, 3'd0, 32'hFFFF_FFFF);
        rd_check("R4 ttb read", 4'd2, 4'd0, 3'd0, 3'd0, 32'hFFFF_C000);
        check("R4 ttb port", ttb_base, 32'hFFFF_C000);
    endtask

    task automatic t_fault_sw;
        wr_reg(4'd5, 4'd0, 3'd0, 32'h0000_00F5);
        wr_reg(4'd5, 4'd0, 3'd1, 32'h0000_0007);
        wr_reg(4'd6, 4'd0, 3'd0, 32'hC000_1000);
        rd_check("R5 dfsr", 4'd5, 4'd0, 3'd0, 3'd0, 32'h0000_00F5);
        rd_check("R5 ifsr", 4'd5, 4'd0, 3'd0, 3'd1, 32'h0000_0007);
        rd_check("R7 far", 4'd6, 4'd0, 3'd0, 3'd0, 32'hC000_1000);
    endtask

    task automatic t_abort;
        // Prefetch abort: only the instruction status changes.
        prefetch_abort = 1'b1; abort_status = 32'h0000_000B; abort_addr = 32'h8000_0040;
        @(posedge clk); @(negedge clk);
        prefetch_abort = 1'b0;
        rd_check("R6 ifsr on prefetch", 4'd5, 4'd0, 3'd0, 3'd1, 32'h0000_000B);
        rd_check("R6 far kept on prefetch", 4'd6, 4'd0, 3'd0, 3'd0, 32'hC000_1000);
        rd_check("R6 dfsr kept on prefetch", 4'd5, 4'd0, 3'd0, 3'd0, 32'h0000_00F5);
        // Data abort colliding with a software write to the data status.
        data_abort = 1'b1; abort_status = 32'h0000_0015; abort_addr = 32'h2000_0104;
        access(1'b1, 4'd5, 4'd0, 3'd0, 3'd0, 32'h0000_0AAA);
        data_abort = 1'b0;
        rd_check("R6 dfsr abort wins", 4'd5, 4'd0, 3'd0, 3'd0, 32'h0000_0015);
        rd_check("R6 far on data abort", 4'd6, 4'd0, 3'd0, 3'd0, 32'h2000_0104);
    endtask

    task automatic maint_one(input logic [3:0] crn, input logic [3:0] crm,
                             input logic [2:0] opc2, input logic [4:0] code,
                             input logic [31:0] arg);
        wr_reg(crn, crm, opc2, arg);
        check("R8 strobe", {31'd0, maint_valid}, 32'd1);
        check("R8 code", {27'd0, maint_op}, {27'd0, code});
        check("R8 arg", maint_arg, arg);
        @(negedge clk);
        check("R8 strobe one cycle", {31'd0, maint_valid}, 32'd0);
        check("R8 idle code", {27'd0, maint_op}, 32'd0);
    endtask

    task automatic t_maint;
        maint_one(4'd7, 4'd7, 3'd0, 5'd1, 32'h0);
        maint_one(4'd7, 4'd10, 3'd4, 5'd13, 32'h0);
        maint_one(4'd7, 4'd0, 3'd4, 5'd14, 32'h0);
        maint_one(4'd7, 4'd14, 3'd2, 5'd12, 32'h4000_00E0);
        maint_one(4'd7, 4'd13, 3'd1, 5'd5, 32'h0010_0020);
        maint_one(4'd8, 4'd7, 3'd1, 5'd16, 32'h8000_1000);
        maint_one(4'd8, 4'd6, 3'd0, 5'd19, 32'h0);
    endtask

    task automatic t_undef;
        wr_reg(4'd7, 4'd5, 3'd3, 32'h1);
        check("R9 undef cache op", {31'd0, maint_valid}, 32'd0);
        wr_reg(4'd8, 4'd7, 3'd2, 32'h1);
        check("R9 undef tlb op", {31'd0, maint_valid}, 32'd0);
        wr_reg(4'd1, 4'd1, 3'd0, 32'hFFFF_FFFF);
        check("R9 undef secondary keeps ctrl", ctrl_word, 32'h1234_5678);
        rd_check("R9 read maint space", 4'd7, 4'd10, 3'd0, 3'd3, 32'h0);
        check("R9 read no strobe", {31'd0, maint_valid}, 32'd0);
        rd_check("R9 read undefined primary", 4'd4, 4'd0, 3'd0, 3'd0, 32'h0);
        access(1'b1, 4'd1, 4'd0, 3'd1, 3'd0, 32'h0BAD_0BAD);
        check("R10 opc1 write ignored", ctrl_word, 32'h1234_5678);
        access(1'b1, 4'd7, 4'd7, 3'd2, 3'd0, 32'h0);
        check("R10 opc1 no strobe", {31'd0, maint_valid}, 32'd0);
        rd_check("R10 opc1 read zero", 4'd0, 4'd0, 3'd1, 3'd0, 32'h0);
    endtask

    task automatic t_pid;
        wr_reg(4'd13, 4'd0, 3'd0, 32'hFFFF_FFFF);
        rd_check("R11 pid width", 4'd13, 4'd0, 3'd0, 3'd0, 32'h0000_007F);
        check("R11 pid port", {25'd0, proc_id}, 32'h7F);
    endtask

    task automatic t_ctx;
        wr_reg(4'd13, 4'd0, 3'd1, 32'hCAFE_0042);
        check("R12 pulse", {31'd0, ctx_wr_pulse}, 32'd1);
        check("R12 value with pulse", ctx_id, 32'hCAFE_0042);
        @(negedge clk);
        check("R12 pulse one cycle", {31'd0, ctx_wr_pulse}, 32'd0);
        rd_check("R12 readback", 4'd13, 4'd0, 3'd0, 3'd1, 32'hCAFE_0042);
        check("R12 no pulse on read", {31'd0, ctx_wr_pulse}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_read_timing;
        t_ident;
        t_plain;
        t_ttb;
        t_fault_sw;
        t_abort;
        t_maint;
        t_undef;
        t_pid;
        t_ctx;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule